// File: doc/BRIEF.md
# LED Matrix Serial Register Port

This block is the receiving end of a cascadable LED matrix driver. A host talks to it over a serial link with four lines: a register select, an active-low chip select, a shift clock and a data line. The block holds a long dot shift register and a parallel dot latch that drives the pixels. It also holds an 8-bit control shift register and two 7-bit control words. On each rising shift clock edge during an access, the data bit moves into the shift register that was chosen when chip select went low. The pixels and the control words keep their old values until the access is over. The first falling shift clock edge after chip select is released copies the shifted contents into the dot latch, or into one of the two control words.

Two devices can be chained. In serial mode the data-out line carries the far end of the selected shift register, so two dot registers act as one register twice as long. In simultaneous mode the data-out line repeats the data-in line, so several devices can load the same control byte at once.

Top module: `led_matrix_serial_regs`

## Requirements
- R1: An active-low reset (asynchronous) clears the control shift register and both control words to zero. Control word 0 bit 6 = 0 means sleep, so reset leaves the display asleep.
- R2: `reg_sel` is captured when `cs_n` falls (0 = dot register, 1 = control register). Changing `reg_sel` while `cs_n` stays low does not redirect the access.
- R3: On each rising `sclk` edge with `cs_n` low, `sdi` enters bit 0 of the selected shift register and every bit moves one place toward the top. The shift register that was not selected keeps its contents.
- R4: The commit happens on the first falling `sclk` edge at which `cs_n` is high after an access. Before that edge, `dot_latch`, `cw0` and `cw1` keep their old values.
- R5: `dot_latch` keeps the last committed pattern while a new one is shifted in. After a full write of DOT_BITS bits, the first bit sent sits at `dot_latch[DOT_BITS-1]` and the last at bit 0. A 1 lights its pixel.
- R6: Control bytes are sent MSB first. At commit, bit 7 of the control shift register picks the target: 0 loads `cw0` and 1 loads `cw1`, in both cases with bits 6..0. The other word keeps its value. The fields of `cw0` are bits 3..0 PWM duty, bits 5..4 peak current and bit 6 awake. The fields of `cw1` are bit 0 data-out mode and bit 1 prescaler select (0 = divide by 1, 1 = divide by 8).
- R7: When `cw1[0]`=1 (simultaneous mode), `sdo` follows `sdi`. When `cw1[0]`=0 (serial mode), `sdo` is the top bit of the selected shift register: `dot` bit DOT_BITS-1 or control bit 7.
- R8: Reset does not change the dot shift register or `dot_latch`.
- R9: An access with fewer bits than the register length still commits the shift register as it stands. The old bits are moved up by the number of bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift clock; rising edge shifts, falling edge commits |
| cs_n | input | 1 | Active-low chip select framing an access |
| reg_sel | input | 1 | Register select captured when `cs_n` falls |
| sdi | input | 1 | Serial data in |
| dot_latch | output | DOT_BITS | Committed pixel pattern |
| cw0 | output | CW_BITS | Control word 0 (PWM, peak current, awake) |
| cw1 | output | CW_BITS | Control word 1 (data-out mode, prescaler) |
| sdo | output | 1 | Serial data out for cascading |

## Verification
A shifted bit shows up in the shift register, and in serial mode on `sdo`, right after the rising edge that takes it. A commit shows up half a period after the bench releases `cs_n`, at the falling edge of that same cycle. In simultaneous mode `sdo` changes with `sdi` after no clock edge at all. The bench drives inputs 1 ns after each rising edge. It checks its reference model 1.5 ns after the falling edge, and it checks that nothing has committed early at 0.5 ns before that falling edge. This way every result is read in the half-period where it is due, not one edge late.

// File: rtl/led_matrix_serial_regs.sv
module led_matrix_serial_regs #(
  parameter int DOT_BITS = 160,
  parameter int CW_BITS  = 7
) (
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                reg_sel,
  input  logic                sdi,
  output logic [DOT_BITS-1:0] dot_latch,
  output logic [CW_BITS-1:0]  cw0,
  output logic [CW_BITS-1:0]  cw1,
  output logic                sdo
);
  localparam int CTRL_BITS = CW_BITS + 1;

  logic [DOT_BITS-1:0]  dot_sr;
  logic [CTRL_BITS-1:0] ctrl_sr;
  logic                 sel_q;
  logic                 armed;

  wire commit   = cs_n & armed;
  wire dot_shift  = ~cs_n & ~sel_q;
  wire ctrl_shift = ~cs_n & sel_q;

  always_ff @(negedge cs_n or negedge rst_n)
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= reg_sel;

  always_ff @(posedge sclk)
    if (dot_shift) dot_sr <= {dot_sr[DOT_BITS-2:0], sdi};

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n)          ctrl_sr <= '0;
    else if (ctrl_shift) ctrl_sr <= {ctrl_sr[CTRL_BITS-2:0], sdi};

  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= ~cs_n;

  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n) begin
      cw0 <= '0;
      cw1 <= '0;
    end else if (commit && sel_q) begin
      if (ctrl_sr[CTRL_BITS-1]) cw1 <= ctrl_sr[CW_BITS-1:0];
      else                      cw0 <= ctrl_sr[CW_BITS-1:0];
    end

  always_ff @(negedge sclk)
    if (commit && !sel_q) dot_latch <= dot_sr;

  assign sdo = cw1[0] ? sdi : (sel_q ? ctrl_sr[CTRL_BITS-1] : dot_sr[DOT_BITS-1]);

  // R1
  reset_clear_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !$past(rst_n) |-> (cw0 == '0 && cw1 == '0));

  // R2
  sel_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(sel_q));

  // R3
  ctrl_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    dot_shift |=> $stable(ctrl_sr));

  // R3
  ctrl_shift_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    ctrl_shift |=> (ctrl_sr[0] == $past(sdi)));

  // R4
  no_early_commit_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    !cs_n |=> ($stable(cw0) && $stable(cw1)));

  // R6
  cw0_keep_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    ctrl_sr[CTRL_BITS-1] |=> $stable(cw0));

  // R6
  cw1_keep_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    !ctrl_sr[CTRL_BITS-1] |=> $stable(cw1));
endmodule

// File: tb/led_matrix_serial_regs_tb.sv
`timescale 1ns/1ps
module led_matrix_serial_regs_tb_top;
  localparam int N = 160;
  localparam int W = 7;

  logic rst_n = 1'b1, sclk = 1'b0, cs_n = 1'b1, reg_sel = 1'b0, sdi = 1'b0;
  logic [N-1:0] dot_latch;
  logic [W-1:0] cw0, cw1;
  logic sdo;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 sclk = ~sclk;

  led_matrix_serial_regs #(.DOT_BITS(N), .CW_BITS(W)) dut_i (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .reg_sel(reg_sel), .sdi(sdi),
    .dot_latch(dot_latch), .cw0(cw0), .cw1(cw1), .sdo(sdo));

  // behavioural reference model
  bit m_dot[$];
  logic [7:0] m_ctrl = '0;
  logic [W-1:0] m_cw0 = '0, m_cw1 = '0;
  bit m_sel = 0, m_armed = 0, m_latch_known = 0;
  logic [N-1:0] m_latch;

  function automatic logic [N-1:0] dot_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_dot[N-1-i];
    return v;
  endfunction

  always @(negedge cs_n) if (rst_n) m_sel = reg_sel;

  always @(posedge sclk)
    if (rst_n && !cs_n) begin
      if (!m_sel) begin
        m_dot.push_back(sdi);
        if (m_dot.size() > N) void'(m_dot.pop_front());
      end else m_ctrl = {m_ctrl[6:0], sdi};
    end

  always @(negedge sclk)
    if (rst_n) begin
      if (!cs_n) m_armed = 1;
      else if (m_armed) begin
        m_armed = 0;
        if (m_sel) begin
          if (m_ctrl[7]) m_cw1 = m_ctrl[6:0];
          else           m_cw0 = m_ctrl[6:0];
        end else if (m_dot.size() == N) begin
          m_latch = dot_vec();
          m_latch_known = 1;
        end
      end
    end

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  always begin
    @(posedge sclk);
    #4;
    if (rst_n && !done) begin
      chk("R6 cw0 vs model", N'(cw0), N'(m_cw0));
      chk("R6 cw1 vs model", N'(cw1), N'(m_cw1));
      if (m_latch_known) chk("R5 dot latch vs model", dot_latch, m_latch);
      if (m_cw1[0]) chk("R7 sdo simultaneous vs model", N'(sdo), N'(sdi));
      else if (m_sel) chk("R7 sdo control vs model", N'(sdo), N'(m_ctrl[7]));
      else if (m_dot.size() == N) chk("R7 sdo dot vs model", N'(sdo), N'(m_dot[0]));
    end
  end

  task automatic tick();
    @(posedge sclk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_ctrl = '0; m_cw0 = '0; m_cw1 = '0; m_sel = 0; m_armed = 0;
    tick(); tick();
    #1;
    chk("R1 cw0 in reset", N'(cw0), '0);
    chk("R1 cw1 in reset", N'(cw1), '0);
    if (m_latch_known) chk("R8 dot latch kept through reset", dot_latch, m_latch);
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic send(bit rs, logic [N-1:0] data, int nbits, int flip_at);
    reg_sel = rs;
    tick();
    cs_n = 0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = data[i];
      if (i == flip_at) reg_sel = ~reg_sel;
      tick();
    end
    cs_n = 1;
    sdi = 0;
  endtask

  localparam logic [N-1:0] PAT_A = {5{32'hA5C3_0F96}};
  localparam logic [N-1:0] PAT_B = {5{32'h1234_5678}};
  localparam logic [N-1:0] PAT_C = {5{32'hF00D_C3A1}};

  initial begin
    do_reset();

    send(0, PAT_A, N, -1);
    #3 chk("R5 latch after full dot write", dot_latch, PAT_A);
    tick();

    send(0, PAT_B, N, -1);
    #1 chk("R4 latch unchanged before falling edge", dot_latch, PAT_A);
    #2 chk("R4 latch updated at falling edge", dot_latch, PAT_B);
    tick();

    send(1, N'(8'h2A), 8, -1);
    #1 chk("R4 cw0 unchanged before falling edge", N'(cw0), '0);
    #2 chk("R6 cw0 loaded", N'(cw0), N'(7'h2A));
    chk("R6 cw1 untouched", N'(cw1), '0);
    tick();

    send(1, N'(8'h81), 8, -1);
    #3 chk("R6 cw1 loaded", N'(cw1), N'(7'h01));
    chk("R6 cw0 untouched", N'(cw0), N'(7'h2A));
    tick();

    sdi = 1;
    #1 chk("R7 simultaneous sdo high", N'(sdo), N'(1'b1));
    tick();
    sdi = 0;
    #1 chk("R7 simultaneous sdo low", N'(sdo), N'(1'b0));
    tick();

    send(1, N'(8'h80), 8, -1);
    #3 chk("R6 cw1 cleared to serial", N'(cw1), '0);
    tick();

    send(0, PAT_C, N, 80);
    #3 chk("R2 dot write kept its target", dot_latch, PAT_C);
    chk("R2 cw0 unaffected by select change", N'(cw0), N'(7'h2A));
    chk("R2 cw1 unaffected by select change", N'(cw1), '0);
    chk("R7 serial sdo top dot bit", N'(sdo), N'(PAT_C[N-1]));
    tick();

    send(1, N'(8'h35), 8, -1);
    #3 chk("R6 cw0 reloaded", N'(cw0), N'(7'h35));
    tick();
    send(1, N'(3'b101), 3, -1);
    #3 chk("R9 partial control write to cw1", N'(cw1), N'(7'h2D));
    chk("R9 cw0 kept on partial write", N'(cw0), N'(7'h35));
    tick();

    do_reset();
    #3 chk("R8 dot shift register kept through reset", N'(sdo), N'(PAT_C[N-1]));
    tick();

    send(1, N'(8'h40), 8, -1);
    #3 chk("R6 cw0 awake", N'(cw0), N'(7'h40));
    tick();
    send(0, N'(4'b1001), 4, -1);
    #3 chk("R3 R9 partial dot write over untouched shift register", dot_latch,
           {PAT_C[N-5:0], 4'b1001});
    tick();

    repeat (3) tick();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: R1 to end of sequence not reached, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule